// File: doc/BRIEF.md
# Two-Level Barrier Bridge

This block joins a cluster's local barrier ring to a global ring of cluster controllers. Both rings carry bit-serial barrier packets. Each packet is a barrier identifier followed by a remaining-participant count. Each ring passes through the block with one bit-time of delay. That delay gives the block time to decode a packet's identifier before the packet's count field goes out.

Software binds a local barrier to a global barrier with a request that gives both identifiers. For such a barrier, the local packet's count is set to the number of local participants plus one. When all local nodes have checked in, the local packet therefore reads one rather than zero. The local nodes stay held, and the block records that the cluster is complete. On the next pass of the matching global packet, the block checks the whole cluster in by decrementing that packet's count in flight. The global count starts at the number of participating clusters. When the matching global packet later arrives with count zero, the block writes zeros into the count field of the next matching local packet. That zero count releases every local node. Two comparator slots work in parallel, so at most two global barriers can be in progress at once.

Top module: `global_barrier_bridge`

## Requirements
- R1: Each ring output repeats its input one clock later. This covers the frame strobe and every identifier bit. A packet starts with the strobe high on its first bit. It carries LID_W (local ring) or GID_W (global ring) identifier bits, LSB first, then CNT_W count bits, LSB first, in two's complement.
- R2: A request is accepted into a free slot at the clock edge where it is seen. `busy` is high exactly when all SLOTS slots are occupied. A request made while `busy` is high is ignored and has no later effect on either ring.
- R3: An armed slot moves to pending global check-in when a local packet with its local identifier ends with a count of exactly one. Any other count leaves the slot armed.
- R4: A pending slot decrements the count of the next global packet with its global identifier by exactly one, with full borrow propagation and wrap (8 becomes 7, 0 becomes 15). It does this once only.
- R5: Global packets whose identifier matches no pending slot pass unchanged.
- R6: A checked-in slot that sees its global packet end with count zero forces the count field of the next local packet with its local identifier to all zeros. The slot is then freed.
- R7: Local packets are altered only as described in R6. The block never sets a local output bit that was clear at the input.
- R8: After reset, both ring outputs are low, `busy` is low and all slots are free.
- R9: Two slots bound to different barriers advance independently and concurrently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| locRxBit | input | 1 | Local ring serial data in |
| locRxFrame | input | 1 | Local ring first-bit strobe in |
| locTxBit | output | 1 | Local ring serial data out |
| locTxFrame | output | 1 | Local ring first-bit strobe out |
| gloRxBit | input | 1 | Global ring serial data in |
| gloRxFrame | input | 1 | Global ring first-bit strobe in |
| gloTxBit | output | 1 | Global ring serial data out |
| gloTxFrame | output | 1 | Global ring first-bit strobe out |
| reqValid | input | 1 | Bind request strobe |
| reqLocalId | input | LID_W | Local barrier identifier to bind |
| reqGlobalId | input | GID_W | Global barrier identifier to bind |
| busy | output | 1 | All slots occupied |

## Verification
On every cycle, the assertions check the following:
- Both frame strobes are delayed by exactly one cycle.
- Global identifier bits are never altered.
- The local ring can only clear bits, never set them.
- `busy` can only rise right after a request.

Other behaviour depends on the sequence of packets, so only the bench's scenarios can show it:
- the count-of-one trigger, and that it does not fire on other counts;
- the single in-flight decrement with its borrow chain;
- the forced zero that follows a global zero;
- the refusal of a third binding;
- two barriers running side by side.

// File: rtl/gbb_pkg.sv
package gbb_pkg;
  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_ARMED,
    SLOT_JOIN,
    SLOT_CHECKED,
    SLOT_RELEASE
  } slot_state_t;

  typedef struct packed {
    logic decGlobal;
    logic zeroLocal;
  } ctrl_strobe_t;
endpackage

// File: rtl/gbb_lane.sv
module gbb_lane #(
  parameter int ID_W     = 3,
  parameter int CNT_W    = 4,
  parameter bit EDIT_DEC = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             rxFrame,
  input  logic             editEn,
  output logic             txBit,
  output logic             txFrame,
  output logic [ID_W-1:0]  headId,
  output logic             cntStart,
  output logic             pktEnd,
  output logic [ID_W-1:0]  pktId,
  output logic [CNT_W-1:0] pktCnt
);
  localparam int PKT = ID_W + CNT_W;
  localparam int PW  = $clog2(PKT + 1);

  logic [PW-1:0]   posQ, inPos;
  logic [PKT-1:0]  pktQ, pktNext;
  logic [ID_W-1:0] idQ;
  logic            dBitQ, dFrameQ, actQ, actCur, actNext, inCount;

  // position of the bit now entering; posQ is the position of the bit leaving
  always_comb begin
    if (rxFrame)                 inPos = '0;
    else if (posQ >= PW'(PKT))   inPos = PW'(PKT);
    else                         inPos = posQ + 1'b1;
  end

  assign pktNext  = {rxBit, pktQ[PKT-1:1]};
  assign pktEnd   = (inPos == PW'(PKT - 1));
  assign pktId    = pktNext[ID_W-1:0];
  assign pktCnt   = pktNext[PKT-1:ID_W];
  assign headId   = idQ;
  assign cntStart = (posQ == PW'(ID_W));
  assign inCount  = (posQ >= PW'(ID_W)) && (posQ < PW'(PKT));
  assign actCur   = cntStart ? editEn : actQ;
  assign txFrame  = dFrameQ;

  generate
    if (EDIT_DEC) begin : g_dec
      // serial borrow: invert while borrow pending, borrow ends at first one
      assign txBit   = (inCount && actCur) ? ~dBitQ : dBitQ;
      assign actNext = inCount && actCur && !dBitQ;
    end else begin : g_zero
      assign txBit   = (inCount && actCur) ? 1'b0 : dBitQ;
      assign actNext = inCount && actCur;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ    <= PW'(PKT);
      pktQ    <= '0;
      idQ     <= '0;
      dBitQ   <= 1'b0;
      dFrameQ <= 1'b0;
      actQ    <= 1'b0;
    end else begin
      posQ    <= inPos;
      pktQ    <= pktNext;
      dBitQ   <= rxBit;
      dFrameQ <= rxFrame;
      actQ    <= actNext;
      if (inPos == PW'(ID_W - 1)) idQ <= pktNext[PKT-1 -: ID_W];
    end
  end
endmodule

// File: rtl/gbb_datapath.sv
module gbb_datapath
  import gbb_pkg::*;
#(
  parameter int LID_W = 3,
  parameter int GID_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locRxBit,
  input  logic              locRxFrame,
  output logic              locTxBit,
  output logic              locTxFrame,
  input  logic              gloRxBit,
  input  logic              gloRxFrame,
  output logic              gloTxBit,
  output logic              gloTxFrame,
  input  ctrl_strobe_t      strobe,
  output logic [LID_W-1:0]  locHeadId,
  output logic              locCntStart,
  output logic              locPktEnd,
  output logic [LID_W-1:0]  locPktId,
  output logic [CNT_W-1:0]  locPktCnt,
  output logic [GID_W-1:0]  gloHeadId,
  output logic              gloCntStart,
  output logic              gloPktEnd,
  output logic [GID_W-1:0]  gloPktId,
  output logic [CNT_W-1:0]  gloPktCnt
);
  gbb_lane #(.ID_W(LID_W), .CNT_W(CNT_W), .EDIT_DEC(1'b0)) u_locLane (
    .clk(clk), .rstN(rstN), .rxBit(locRxBit), .rxFrame(locRxFrame),
    .editEn(strobe.zeroLocal), .txBit(locTxBit), .txFrame(locTxFrame),
    .headId(locHeadId), .cntStart(locCntStart), .pktEnd(locPktEnd),
    .pktId(locPktId), .pktCnt(locPktCnt)
  );

  gbb_lane #(.ID_W(GID_W), .CNT_W(CNT_W), .EDIT_DEC(1'b1)) u_gloLane (
    .clk(clk), .rstN(rstN), .rxBit(gloRxBit), .rxFrame(gloRxFrame),
    .editEn(strobe.decGlobal), .txBit(gloTxBit), .txFrame(gloTxFrame),
    .headId(gloHeadId), .cntStart(gloCntStart), .pktEnd(gloPktEnd),
    .pktId(gloPktId), .pktCnt(gloPktCnt)
  );
endmodule

// File: rtl/gbb_ctrl.sv
module gbb_ctrl
  import gbb_pkg::*;
#(
  parameter int LID_W = 3,
  parameter int GID_W = 3,
  parameter int CNT_W = 4,
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LID_W-1:0]  reqLocalId,
  input  logic [GID_W-1:0]  reqGlobalId,
  output logic              busy,
  input  logic [LID_W-1:0]  locHeadId,
  input  logic              locCntStart,
  input  logic              locPktEnd,
  input  logic [LID_W-1:0]  locPktId,
  input  logic [CNT_W-1:0]  locPktCnt,
  input  logic [GID_W-1:0]  gloHeadId,
  input  logic              gloCntStart,
  input  logic              gloPktEnd,
  input  logic [GID_W-1:0]  gloPktId,
  input  logic [CNT_W-1:0]  gloPktCnt,
  output ctrl_strobe_t      strobe
);
  slot_state_t      stArr  [SLOTS];
  logic [LID_W-1:0] lidArr [SLOTS];
  logic [GID_W-1:0] gidArr [SLOTS];
  logic [SLOTS-1:0] relMatch, joinMatch, relSel, joinSel, freeSel;

  // parallel comparators, one per slot
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      relMatch[i]  = (stArr[i] == SLOT_RELEASE) && (lidArr[i] == locHeadId);
      joinMatch[i] = (stArr[i] == SLOT_JOIN)    && (gidArr[i] == gloHeadId);
    end
  end

  // lowest index wins each choice
  always_comb begin
    logic fr, fj, ff;
    fr = 1'b0; fj = 1'b0; ff = 1'b0;
    relSel = '0; joinSel = '0; freeSel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (relMatch[i] && !fr)  begin relSel[i]  = 1'b1; fr = 1'b1; end
      if (joinMatch[i] && !fj) begin joinSel[i] = 1'b1; fj = 1'b1; end
      if ((stArr[i] == SLOT_IDLE) && !ff) begin freeSel[i] = 1'b1; ff = 1'b1; end
    end
  end

  assign busy             = (freeSel == '0);
  assign strobe.zeroLocal = locCntStart && (relSel != '0);
  assign strobe.decGlobal = gloCntStart && (joinSel != '0);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      slot_state_t      stQ;
      logic [LID_W-1:0] lidQ;
      logic [GID_W-1:0] gidQ;

      assign stArr[g]  = stQ;
      assign lidArr[g] = lidQ;
      assign gidArr[g] = gidQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stQ  <= SLOT_IDLE;
          lidQ <= '0;
          gidQ <= '0;
        end else begin
          unique case (stQ)
            SLOT_IDLE:
              if (reqValid && freeSel[g]) begin
                stQ  <= SLOT_ARMED;
                lidQ <= reqLocalId;
                gidQ <= reqGlobalId;
              end
            SLOT_ARMED:
              if (locPktEnd && (locPktId == lidQ) && (locPktCnt == CNT_W'(1)))
                stQ <= SLOT_JOIN;
            SLOT_JOIN:
              if (strobe.decGlobal && joinSel[g]) stQ <= SLOT_CHECKED;
            SLOT_CHECKED:
              if (gloPktEnd && (gloPktId == gidQ) && (gloPktCnt == '0))
                stQ <= SLOT_RELEASE;
            SLOT_RELEASE:
              if (strobe.zeroLocal && relSel[g]) stQ <= SLOT_IDLE;
            default: stQ <= SLOT_IDLE;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/global_barrier_bridge.sv
module global_barrier_bridge
  import gbb_pkg::*;
#(
  parameter int LID_W = 3,
  parameter int GID_W = 3,
  parameter int CNT_W = 4,
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locRxBit,
  input  logic             locRxFrame,
  output logic             locTxBit,
  output logic             locTxFrame,
  input  logic             gloRxBit,
  input  logic             gloRxFrame,
  output logic             gloTxBit,
  output logic             gloTxFrame,
  input  logic             reqValid,
  input  logic [LID_W-1:0] reqLocalId,
  input  logic [GID_W-1:0] reqGlobalId,
  output logic             busy
);
  ctrl_strobe_t     strobe;
  logic [LID_W-1:0] locHeadId, locPktId;
  logic [GID_W-1:0] gloHeadId, gloPktId;
  logic [CNT_W-1:0] locPktCnt, gloPktCnt;
  logic             locCntStart, locPktEnd, gloCntStart, gloPktEnd;

  gbb_datapath #(.LID_W(LID_W), .GID_W(GID_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .locRxBit(locRxBit), .locRxFrame(locRxFrame),
    .locTxBit(locTxBit), .locTxFrame(locTxFrame),
    .gloRxBit(gloRxBit), .gloRxFrame(gloRxFrame),
    .gloTxBit(gloTxBit), .gloTxFrame(gloTxFrame),
    .strobe(strobe),
    .locHeadId(locHeadId), .locCntStart(locCntStart), .locPktEnd(locPktEnd),
    .locPktId(locPktId), .locPktCnt(locPktCnt),
    .gloHeadId(gloHeadId), .gloCntStart(gloCntStart), .gloPktEnd(gloPktEnd),
    .gloPktId(gloPktId), .gloPktCnt(gloPktCnt)
  );

  gbb_ctrl #(.LID_W(LID_W), .GID_W(GID_W), .CNT_W(CNT_W), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLocalId(reqLocalId), .reqGlobalId(reqGlobalId),
    .busy(busy),
    .locHeadId(locHeadId), .locCntStart(locCntStart), .locPktEnd(locPktEnd),
    .locPktId(locPktId), .locPktCnt(locPktCnt),
    .gloHeadId(gloHeadId), .gloCntStart(gloCntStart), .gloPktEnd(gloPktEnd),
    .gloPktId(gloPktId), .gloPktCnt(gloPktCnt),
    .strobe(strobe)
  );
endmodule

// File: rtl/global_barrier_bridge_chk.sv
module global_barrier_bridge_chk #(
  parameter int GID_W = 3,
  parameter int CNT_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic locRxBit,
  input logic locRxFrame,
  input logic locTxBit,
  input logic locTxFrame,
  input logic gloRxBit,
  input logic gloRxFrame,
  input logic gloTxBit,
  input logic gloTxFrame,
  input logic reqValid,
  input logic busy
);
  localparam int PKT = GID_W + CNT_W;
  localparam int PW  = $clog2(PKT + 1);

  logic [PW-1:0] tPosQ, tPos;

  always_comb begin
    if (gloTxFrame)             tPos = '0;
    else if (tPosQ >= PW'(PKT)) tPos = PW'(PKT);
    else                        tPos = tPosQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tPosQ <= PW'(PKT);
    else       tPosQ <= tPos;
  end

  a_r1_loc_frame_delay: assert property (@(posedge clk) disable iff (!rstN)
    locTxFrame == $past(locRxFrame));

  a_r1_glo_frame_delay: assert property (@(posedge clk) disable iff (!rstN)
    gloTxFrame == $past(gloRxFrame));

  a_r1_glo_id_unchanged: assert property (@(posedge clk) disable iff (!rstN)
    (tPos < PW'(GID_W)) |-> (gloTxBit == $past(gloRxBit)));

  a_r7_loc_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    locTxBit |-> $past(locRxBit));

  a_r2_busy_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
endmodule

bind global_barrier_bridge global_barrier_bridge_chk #(.GID_W(GID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .locRxBit(locRxBit), .locRxFrame(locRxFrame),
  .locTxBit(locTxBit), .locTxFrame(locTxFrame),
  .gloRxBit(gloRxBit), .gloRxFrame(gloRxFrame),
  .gloTxBit(gloTxBit), .gloTxFrame(gloTxFrame),
  .reqValid(reqValid), .busy(busy)
);

// File: tb/global_barrier_bridge_bench.sv
`timescale 1ns/1ps
module global_barrier_bridge_bench;
  localparam int LID_W = 3;
  localparam int GID_W = 3;
  localparam int CNT_W = 4;
  localparam int SLOTS = 2;
  localparam int PKT   = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic locRxBit = 1'b0, locRxFrame = 1'b0, gloRxBit = 1'b0, gloRxFrame = 1'b0;
  logic reqValid = 1'b0;
  logic [LID_W-1:0] reqLocalId = '0;
  logic [GID_W-1:0] reqGlobalId = '0;
  logic locTxBit, locTxFrame, gloTxBit, gloTxFrame, busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  global_barrier_bridge #(.LID_W(LID_W), .GID_W(GID_W), .CNT_W(CNT_W), .SLOTS(SLOTS))
    u_global_barrier_bridge (
      .clk(clk), .rstN(rstN),
      .locRxBit(locRxBit), .locRxFrame(locRxFrame),
      .locTxBit(locTxBit), .locTxFrame(locTxFrame),
      .gloRxBit(gloRxBit), .gloRxFrame(gloRxFrame),
      .gloTxBit(gloTxBit), .gloTxFrame(gloTxFrame),
      .reqValid(reqValid), .reqLocalId(reqLocalId), .reqGlobalId(reqGlobalId),
      .busy(busy));

  // {req tag, op, a, b, expected}; op 1 = local packet (a=id, b=count),
  // op 2 = global packet (a=id, b=count), op 3 = bind request (a=local, b=global, exp=busy)
  localparam int NVEC = 27;
  localparam logic [19:0] VEC [NVEC] = '{
    20'h71533, // R7 local packet, no slot bound
    20'h52222, // R5 global packet, no slot bound
    20'h23520, // R2 bind local 5 to global 2
    20'h31522, // R3 count two does not trigger
    20'h52222, // R5 armed slot does not decrement
    20'h31511, // R3 count one triggers check-in
    20'h52322, // R5 other global id untouched
    20'h42221, // R4 in-flight decrement
    20'h42211, // R4 only once
    20'h71511, // R7 no release before global zero
    20'h62200, // R6 global zero seen
    20'h71433, // R7 other local id while release pending
    20'h61510, // R6 forced zero count
    20'h61511, // R6 slot freed afterwards
    20'h93160, // R9 bind local 1 to global 6
    20'h23271, // R2 bind local 2 to global 7, now full
    20'h23351, // R2 third bind refused
    20'h21311, // R2 refused binding has no local effect
    20'h22533, // R2 refused binding never decrements
    20'h91111, // R9 slot A completes locally
    20'h91211, // R9 slot B completes locally
    20'h42787, // R4 borrow through three zeros
    20'h92610, // R9 slot A decrement to zero
    20'h92600, // R9 slot A sees zero
    20'h91211, // R9 slot B still held
    20'h91110, // R9 slot A released
    20'h23351  // R2 freed slot reused, full again
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendPkt(input bit glo, input int id, input int cnt,
                         output int outId, output int outCnt, output bit frameOk);
    logic [PKT-1:0] pkt, got;
    pkt = {cnt[3:0], id[2:0]};
    got = '0;
    frameOk = 1'b1;
    for (int b = 0; b <= PKT; b++) begin
      @(negedge clk);
      if (b > 0) begin
        got[b-1] = glo ? gloTxBit : locTxBit;
        if ((glo ? gloTxFrame : locTxFrame) != (b == 1)) frameOk = 1'b0;
      end
      if (glo) begin
        gloRxBit   = (b < PKT) ? pkt[b] : 1'b0;
        gloRxFrame = (b == 0);
      end else begin
        locRxBit   = (b < PKT) ? pkt[b] : 1'b0;
        locRxFrame = (b == 0);
      end
    end
    outId  = int'(got[2:0]);
    outCnt = int'(got[6:3]);
    repeat (2) @(negedge clk);
  endtask

  task automatic bindReq(input int lid, input int gid);
    @(negedge clk);
    reqValid = 1'b1; reqLocalId = lid[2:0]; reqGlobalId = gid[2:0];
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int oId, oCnt;
    bit fOk;
    string tag;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(locTxBit == 0 && locTxFrame == 0, "R8 local outputs", int'(locTxBit), 0);
    check(gloTxBit == 0 && gloTxFrame == 0, "R8 global outputs", int'(gloTxBit), 0);
    check(busy == 0, "R8 busy", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int rq, op, a, b, e;
      rq = int'(VEC[v][19:16]); op = int'(VEC[v][15:12]);
      a  = int'(VEC[v][11:8]);  b  = int'(VEC[v][7:4]); e = int'(VEC[v][3:0]);
      tag = $sformatf("R%0d vec%0d", rq, v);
      if (op == 3) begin
        bindReq(a, b);
        check(busy == e[0], {tag, " busy"}, int'(busy), e);
      end else begin
        sendPkt(op == 2, a, b, oId, oCnt, fOk);
        check(oCnt == e, {tag, " count"}, oCnt, e);
        check(oId == a, {tag, " R1 id"}, oId, a);
        check(fOk, {tag, " R1 frame"}, int'(fOk), 1);
      end
    end

    // R8 reset in mid-operation frees every slot
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 0, "R8 busy after reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    sendPkt(1'b0, 3, 1, oId, oCnt, fOk);
    sendPkt(1'b1, 5, 3, oId, oCnt, fOk);
    check(oCnt == 3, "R8 no leftover binding", oCnt, 3);

    // R4 wrap from zero
    bindReq(6, 4);
    sendPkt(1'b0, 6, 1, oId, oCnt, fOk);
    sendPkt(1'b1, 4, 0, oId, oCnt, fOk);
    check(oCnt == 15, "R4 wrap to fifteen", oCnt, 15);

    // R3 count zero on an armed slot does not trigger
    bindReq(2, 3);
    sendPkt(1'b0, 2, 0, oId, oCnt, fOk);
    sendPkt(1'b1, 3, 5, oId, oCnt, fOk);
    check(oCnt == 5, "R3 zero count no trigger", oCnt, 5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule